// File: doc/BRIEF.md
# CSMA/CD Transmit Collision Backoff Controller

This block decides what a half-duplex 10 Mb/s Ethernet transmitter does after a collision. It does not move frame data. It watches a bit-time tick, a collision detector, receive carrier sense and the start and end of each transmission attempt. It counts the bit times of the current attempt. On a collision it drives a jam window, then takes one of three paths:
- It schedules a retry after a truncated binary exponential backoff followed by an inter-packet gap.
- It declares a late collision.
- It gives up once the attempt budget is spent.

The backoff draw comes from a free-running maximal-length LFSR. Its low bits are masked to k = min(n, cap) bits, where n is the number of collisions of the current frame so far. When the frame is abandoned, the block pulses a FIFO flush, drops its transmit data request and raises an interrupt unless the mask is set.

An optional busy-channel mode freezes the backoff and gap countdowns while receive carrier is present. Nodes outside the collision can then use the medium while the colliding stations wait.

Top module: `csma_backoff_ctrl`

## Requirements
- R1: After reset, tx_req, jam_en, retry_go, fifo_flush, late_col, retry_fail and irq are all 0.
- R2: A tx_start pulse while idle raises tx_req from the next cycle. It clears late_col and retry_fail and restarts the frame's collision count at n = 0. A tx_done without a collision in the same cycle ends the frame: tx_req drops and the collision count returns to 0.
- R3: A col_det during a transmit attempt raises jam_en from the next cycle for exactly JAM_BITS bit ticks. If col_det and tx_done arrive in the same cycle, the collision wins.
- R4: A collision is late when at least SLOT_BITS bit ticks of the attempt have been counted when col_det is sampled. After the jam, late_col is set and no retry_go follows.
- R5: After the jam of the nth non-late collision (n < ATTEMPT_LIMIT), bit_tick is held high every cycle. retry_go is then high for one cycle, r*SLOT_BITS + GAP_BITS + 1 cycles after the first cycle with jam_en low. Here 0 <= r < 2^min(n, BACKOFF_CAP), and r is the LFSR's low bits masked to that width.
- R6: The next transmit attempt starts with its bit count at 0 in the cycle after retry_go.
- R7: With freeze_mode = 1, each bit tick with crs high during the backoff or gap countdown is not counted, which extends the wait by that many cycles. With freeze_mode = 0, crs has no effect on the wait.
- R8: The ATTEMPT_LIMIT-th non-late collision of a frame sets retry_failure (retry_fail) after its jam, and no retry follows.
- R9: On a late collision or retry failure, fifo_flush is high for exactly one cycle, in the first cycle with jam_en low. In that same cycle tx_req is 0.
- R10: irq is 1 exactly when late_col or retry_fail is set and irq_mask is 0. Both flags hold until the next tx_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One pulse per network bit time |
| tx_start | input | 1 | Request to begin transmitting a new frame |
| tx_done | input | 1 | Current attempt finished without collision |
| col_det | input | 1 | Collision detected on the medium |
| crs | input | 1 | Receive carrier sense |
| freeze_mode | input | 1 | 1 = pause backoff and gap counting while crs is high |
| irq_mask | input | 1 | 1 = suppress the interrupt output |
| tx_req | output | 1 | Transmit data request, high while a frame is in progress |
| jam_en | output | 1 | Jam sequence window |
| retry_go | output | 1 | One-cycle pulse that starts a retransmission |
| fifo_flush | output | 1 | One-cycle pulse to discard the frame |
| late_col | output | 1 | Late collision status |
| retry_fail | output | 1 | Retry limit exhausted status |
| irq | output | 1 | Interrupt request |

## Verification
The collision detector and the end-of-transmit indication can land in the same cycle. The bench provokes this by raising col_det and tx_done on one clock edge. It judges the result by seeing jam_en rise and a legal backoff follow, rather than the frame closing. The slot boundary is a second coincidence: the bit counter reaching SLOT_BITS as a collision is sampled. The bench places collisions at SLOT_BITS-1 and SLOT_BITS ticks and expects a retry in the first case and a late collision in the second. Because the backoff draw is random, each retry delay is checked against the slot grid and the 2^min(n,cap) bound instead of a fixed value.

// File: rtl/csma_bo_pkg.sv
package csma_bo_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_XMIT,
        ST_JAM,
        ST_BACKOFF,
        ST_GAP
    } bo_state_e;

    typedef struct packed {
        logic late;
        logic fail;
    } tx_flags_t;

    function automatic int unsigned exp_width(input int unsigned n, input int unsigned cap);
        return (n < cap) ? n : cap;
    endfunction

    function automatic logic [31:0] low_mask(input int unsigned k);
        return (32'd1 << k) - 32'd1;
    endfunction

endpackage

// File: rtl/bo_lfsr.sv
module bo_lfsr #(
    parameter int          W    = 16,
    parameter logic [W-1:0] TAPS = 16'hD008,
    parameter logic [W-1:0] SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] value
);
    logic [W-1:0] sr;
    logic         fb;

    assign fb    = ^(sr & TAPS);
    assign value = sr;

    always_ff @(posedge clk) begin
        if (rst) sr <= SEED;
        else     sr <= {sr[W-2:0], fb};
    end

    AST_LFSR_ALIVE: assert property (@(posedge clk) disable iff (rst) sr != '0); // R5

endmodule

// File: rtl/bo_tick_timer.sv
module bo_tick_timer #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    input  logic         hold,
    output logic         expired
);
    logic [W-1:0] cnt;

    assign expired = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst)                          cnt <= '0;
        else if (load)                    cnt <= load_val;
        else if (tick && !hold && !expired) cnt <= cnt - 1'b1;
    end

    AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (rst)
        (hold && !load) |=> $stable(cnt)); // R7

endmodule

// File: rtl/csma_backoff_ctrl.sv
module csma_backoff_ctrl
    import csma_bo_pkg::*;
#(
    parameter int SLOT_BITS     = 512,
    parameter int JAM_BITS      = 32,
    parameter int GAP_BITS      = 96,
    parameter int ATTEMPT_LIMIT = 16,
    parameter int BACKOFF_CAP   = 10,
    parameter int LFSR_W        = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_tick,
    input  logic tx_start,
    input  logic tx_done,
    input  logic col_det,
    input  logic crs,
    input  logic freeze_mode,
    input  logic irq_mask,
    output logic tx_req,
    output logic jam_en,
    output logic retry_go,
    output logic fifo_flush,
    output logic late_col,
    output logic retry_fail,
    output logic irq
);
    localparam int BC_W  = $clog2(SLOT_BITS + 1);
    localparam int JC_W  = (JAM_BITS > 1) ? $clog2(JAM_BITS) : 1;
    localparam int AC_W  = $clog2(ATTEMPT_LIMIT + 1);
    localparam int TMR_W = $clog2(((2 ** BACKOFF_CAP) - 1) * SLOT_BITS + GAP_BITS + 1);

    bo_state_e      state, state_nx;
    logic [BC_W-1:0] bit_cnt;
    logic [JC_W-1:0] jam_cnt;
    logic [AC_W-1:0] att_cnt, att_next;
    logic            late_hit;
    tx_flags_t       flags;
    logic            flush_q;

    logic              tmr_load, tmr_expired, hold;
    logic [TMR_W-1:0]  tmr_val;
    logic [LFSR_W-1:0] rnd;
    logic [BACKOFF_CAP-1:0] r_draw;
    logic              jam_last, abandon;

    bo_lfsr #(.W(LFSR_W)) u_lfsr (
        .clk(clk), .rst(rst), .value(rnd)
    );

    bo_tick_timer #(.W(TMR_W)) u_timer (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val),
        .tick(bit_tick), .hold(hold), .expired(tmr_expired)
    );

    assign hold     = freeze_mode & crs;
    assign att_next = att_cnt + 1'b1;
    assign r_draw   = rnd[BACKOFF_CAP-1:0]
                    & BACKOFF_CAP'(low_mask(exp_width(int'(att_next), BACKOFF_CAP)));
    assign jam_last = (state == ST_JAM) && bit_tick && (jam_cnt == JC_W'(JAM_BITS - 1));
    assign abandon  = jam_last && (late_hit || (int'(att_next) >= ATTEMPT_LIMIT));

    always_comb begin
        state_nx = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        retry_go = 1'b0;
        unique case (state)
            ST_IDLE:    if (tx_start) state_nx = ST_XMIT;
            ST_XMIT: begin
                if (col_det)      state_nx = ST_JAM;
                else if (tx_done) state_nx = ST_IDLE;
            end
            ST_JAM: begin
                if (abandon) begin
                    state_nx = ST_IDLE;
                end else if (jam_last) begin
                    state_nx = ST_BACKOFF;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(r_draw) * TMR_W'(SLOT_BITS);
                end
            end
            ST_BACKOFF: begin
                if (tmr_expired && !hold) begin
                    state_nx = ST_GAP;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(GAP_BITS);
                end
            end
            ST_GAP: begin
                if (tmr_expired && !hold) begin
                    state_nx = ST_XMIT;
                    retry_go = 1'b1;
                end
            end
            default:    state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            jam_cnt  <= '0;
            att_cnt  <= '0;
            late_hit <= 1'b0;
            flags    <= '0;
            flush_q  <= 1'b0;
        end else begin
            state   <= state_nx;
            flush_q <= abandon;
            unique case (state)
                ST_IDLE: begin
                    if (tx_start) begin
                        flags   <= '0;
                        att_cnt <= '0;
                        bit_cnt <= '0;
                    end
                end
                ST_XMIT: begin
                    if (col_det) begin
                        late_hit <= (bit_cnt >= BC_W'(SLOT_BITS));
                        jam_cnt  <= '0;
                    end else if (tx_done) begin
                        att_cnt <= '0;
                    end
                    if (bit_tick && bit_cnt < BC_W'(SLOT_BITS))
                        bit_cnt <= bit_cnt + 1'b1;
                end
                ST_JAM: begin
                    if (bit_tick) jam_cnt <= jam_cnt + 1'b1;
                    if (jam_last) begin
                        if (late_hit)        flags.late <= 1'b1;
                        else if (abandon)    flags.fail <= 1'b1;
                        else                 att_cnt    <= att_next;
                    end
                end
                ST_GAP: if (retry_go) bit_cnt <= '0;
                default: ;
            endcase
        end
    end

    assign tx_req     = (state != ST_IDLE);
    assign jam_en     = (state == ST_JAM);
    assign fifo_flush = flush_q;
    assign late_col   = flags.late;
    assign retry_fail = flags.fail;
    assign irq        = (flags.late | flags.fail) & ~irq_mask;

    AST_JAM_FOLLOWS_COL: assert property (@(posedge clk) disable iff (rst)
        $rose(jam_en) |-> $past(col_det)); // R3
    AST_FLUSH_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
        fifo_flush |=> !fifo_flush); // R9
    AST_FLUSH_DROPS_REQ: assert property (@(posedge clk) disable iff (rst)
        fifo_flush |-> (!tx_req && (late_col || retry_fail))); // R9
    AST_ATTEMPT_BOUND: assert property (@(posedge clk) disable iff (rst)
        int'(att_cnt) < ATTEMPT_LIMIT); // R8
    AST_LATE_NO_RETRY: assert property (@(posedge clk) disable iff (rst)
        (jam_en && late_hit) |=> !retry_go); // R4

endmodule

// File: tb/csma_backoff_ctrl_bench.sv
module csma_backoff_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int S   = 8;
    localparam int JAM = 4;
    localparam int GAP = 6;
    localparam int LIM = 16;
    localparam int CAP = 10;
    localparam int H   = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_tick = 1'b1;
    logic tx_start = 1'b0, tx_done = 1'b0, col_det = 1'b0, crs = 1'b0;
    logic freeze_mode = 1'b0, irq_mask = 1'b0;
    logic tx_req, jam_en, retry_go, fifo_flush, late_col, retry_fail, irq;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    csma_backoff_ctrl #(
        .SLOT_BITS(S), .JAM_BITS(JAM), .GAP_BITS(GAP),
        .ATTEMPT_LIMIT(LIM), .BACKOFF_CAP(CAP), .LFSR_W(16)
    ) u_csma_backoff_ctrl (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .tx_start(tx_start),
        .tx_done(tx_done), .col_det(col_det), .crs(crs),
        .freeze_mode(freeze_mode), .irq_mask(irq_mask), .tx_req(tx_req),
        .jam_en(jam_en), .retry_go(retry_go), .fifo_flush(fifo_flush),
        .late_col(late_col), .retry_fail(retry_fail), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic start_frame();
        @(negedge clk); tx_start = 1'b1;
        @(negedge clk); tx_start = 1'b0;
    endtask

    task automatic end_frame();
        tx_done = 1'b1;
        @(negedge clk); tx_done = 1'b0;
    endtask

    task automatic collide(input int n);
        repeat (n) @(negedge clk);
        col_det = 1'b1;
        @(negedge clk); col_det = 1'b0;
    endtask

    task automatic wait_jam(output int jl);
        jl = 0;
        while (jam_en && jl < 1000) begin jl++; @(negedge clk); end
    endtask

    task automatic wait_retry(inout int d);
        while (!retry_go && d < 20000) begin d++; @(negedge clk); end
    endtask

    task automatic chk_backoff(input int d, input int n, input int extra, input string req);
        int x = d - 1 - GAP - extra;
        int nk = (n < CAP) ? n : CAP;
        chk(x >= 0 && (x % S) == 0 && (x / S) < (1 << nk), req, d, 1 + GAP + extra);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk({tx_req, jam_en, retry_go, fifo_flush, late_col, retry_fail, irq} == 7'b0,
            "R1 reset outputs", int'({tx_req, jam_en, retry_go, fifo_flush, late_col, retry_fail, irq}), 0);
    endtask

    task automatic t_normal();
        start_frame();
        chk(tx_req == 1'b1, "R2 tx_req after start", int'(tx_req), 1);
        repeat (10) @(negedge clk);
        end_frame();
        chk(tx_req == 1'b0 && late_col == 1'b0, "R2 frame closes on tx_done", int'({tx_req, late_col}), 0);
    endtask

    task automatic t_boundary_early();
        int jl; int d = 0;
        start_frame();
        collide(S - 1);
        wait_jam(jl);
        chk(jl == JAM, "R3 jam length", jl, JAM);
        chk(late_col == 1'b0 && fifo_flush == 1'b0, "R4 slot-1 collision not late", int'({late_col, fifo_flush}), 0);
        wait_retry(d);
        chk_backoff(d, 1, 0, "R5 first backoff window");
        @(negedge clk);
        chk(tx_req == 1'b1 && jam_en == 1'b0, "R6 retry resumes transmit", int'({tx_req, jam_en}), 2);
        end_frame();
    endtask

    task automatic t_late();
        int jl; int seen = 0; int fl;
        irq_mask = 1'b0;
        start_frame();
        collide(S);
        wait_jam(jl);
        chk(jl == JAM, "R3 jam length on late", jl, JAM);
        chk(late_col == 1'b1 && retry_fail == 1'b0, "R4 late flag", int'({late_col, retry_fail}), 2);
        chk(fifo_flush == 1'b1 && tx_req == 1'b0, "R9 flush and request drop", int'({fifo_flush, tx_req}), 2);
        chk(irq == 1'b1, "R10 irq unmasked", int'(irq), 1);
        fl = 1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (retry_go) seen++;
            if (fifo_flush) fl++;
        end
        chk(seen == 0, "R4 no retry after late collision", seen, 0);
        chk(fl == 1, "R9 flush is one cycle", fl, 1);
        chk(late_col == 1'b1, "R10 late flag holds", int'(late_col), 1);
    endtask

    task automatic t_mask();
        int jl;
        irq_mask = 1'b1;
        start_frame();
        collide(S + 3);
        wait_jam(jl);
        chk(late_col == 1'b1 && irq == 1'b0, "R10 irq masked", int'({late_col, irq}), 2);
        @(negedge clk); irq_mask = 1'b0;
        #1;
        chk(irq == 1'b1, "R10 irq after unmask", int'(irq), 1);
        start_frame();
        chk(late_col == 1'b0 && irq == 1'b0, "R2 start clears flags", int'({late_col, irq}), 0);
        end_frame();
    endtask

    task automatic t_col_and_done();
        int jl; int d = 0;
        start_frame();
        repeat (4) @(negedge clk);
        col_det = 1'b1; tx_done = 1'b1;
        @(negedge clk); col_det = 1'b0; tx_done = 1'b0;
        chk(jam_en == 1'b1 && tx_req == 1'b1, "R3 collision beats tx_done", int'({jam_en, tx_req}), 3);
        wait_jam(jl);
        wait_retry(d);
        chk_backoff(d, 1, 0, "R5 backoff after simultaneous events");
        @(negedge clk);
        end_frame();
    endtask

    task automatic t_freeze(input bit mode);
        int jl; int d = 0;
        freeze_mode = mode;
        start_frame();
        collide(2);
        wait_jam(jl);
        crs = 1'b1;
        repeat (H) begin
            if (retry_go) break;
            d++; @(negedge clk);
        end
        crs = 1'b0;
        wait_retry(d);
        if (mode) chk_backoff(d, 1, H, "R7 freeze extends wait by carrier time");
        else      chk_backoff(d, 1, 0, "R7 carrier ignored without freeze");
        @(negedge clk);
        end_frame();
        freeze_mode = 1'b0;
    endtask

    task automatic t_fail();
        int jl; int d;
        irq_mask = 1'b0;
        start_frame();
        for (int c = 1; c <= LIM; c++) begin
            collide(2);
            wait_jam(jl);
            if (c < LIM) begin
                d = 0;
                wait_retry(d);
                chk_backoff(d, c, 0, $sformatf("R5 backoff collision %0d", c));
                @(negedge clk);
            end
        end
        chk(retry_fail == 1'b1 && late_col == 1'b0, "R8 retry failure flag", int'({retry_fail, late_col}), 2);
        chk(fifo_flush == 1'b1 && tx_req == 1'b0, "R9 flush on retry failure", int'({fifo_flush, tx_req}), 2);
        chk(irq == 1'b1, "R10 irq on retry failure", int'(irq), 1);
        d = 0;
        repeat (20) begin @(negedge clk); if (retry_go) d++; end
        chk(d == 0, "R8 no retry after failure", d, 0);
    endtask

    task automatic t_restart();
        int jl; int d = 0;
        start_frame();
        chk(retry_fail == 1'b0, "R2 new frame clears failure", int'(retry_fail), 0);
        collide(2);
        wait_jam(jl);
        wait_retry(d);
        chk_backoff(d, 1, 0, "R2 collision count restarts at zero");
        @(negedge clk);
        end_frame();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_normal();
        t_boundary_early();
        t_late();
        t_mask();
        t_col_and_done();
        t_freeze(1'b1);
        t_freeze(1'b0);
        t_fail();
        t_restart();
        summary();
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
    end

endmodule